// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Neighbour Swap

This block chooses which of four DMA channels owns the transfer engine. The starting rank is by channel number: the lowest number wins. Each channel also supplies a 3-bit bandwidth field. When that field is all zero, the channel trades places with its next lower-numbered neighbour. A swap joins exactly two neighbours. A channel that is already in a swap cannot join a second one, so the changes never ripple down the list.

The winner is registered. The grant stays locked on that channel for as long as it keeps its request high. The cycle after the holder drops its request, the arbiter decides again among the requests then present, using the rank the bandwidth fields give at that moment. Executing the transfer, generating addresses and synchronising the request lines are all handled outside this block.

Top module: `dma_prio_arb`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no request, `gnt` is all zeros, `gnt_idx` is 0 and `gnt_vld` is 0.
- R2: When every channel's bandwidth field is non-zero, an arbitration grants the requesting channel with the lowest number. Field of channel i is `ch_bw[3*i+2:3*i]`.
- R3: A channel i (1 to 3) whose field is 000, while channel i-1's field is non-zero, ranks directly above channel i-1 and keeps its place relative to every other channel. Example: only channel 3 zero gives the rank 0,1,3,2.
- R4: Swaps never chain. When channels 1 and 2 both have zero fields, the rank is 1,0,2,3 and channel 2's zero field changes nothing.
- R5: Neighbours with equal fields, including both zero, keep ascending order between themselves.
- R6: Channel 0's field never changes the rank.
- R7: An arbitration uses `ch_req` and `ch_bw` sampled at a rising edge. The result shows on `gnt`, `gnt_idx` and `gnt_vld` right after that edge. A granted channel was requesting at that edge.
- R8: While the granted channel keeps its request high, the grant does not change, whatever the other requests or the fields do.
- R9: At the first edge where the granted channel's request is low, a new arbitration runs among the requests present at that edge.
- R10: `gnt` is one-hot or zero, `gnt_vld` is high exactly when `gnt` is non-zero, and `gnt_idx` is the binary index of the set bit (0 when idle). With no request at an edge, the next state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 4 | Request line per channel, bit i for channel i |
| ch_bw | input | 12 | Bandwidth field per channel, 3 bits each, channel i at bits 3*i+2..3*i |
| gnt | output | 4 | One-hot grant |
| gnt_idx | output | 2 | Binary index of the granted channel |
| gnt_vld | output | 1 | A grant is active |

## Verification
A wrong swap vector or rank list shows up as a wrong `gnt_idx` one edge after the bad fields are sampled. It can only show when an arbitration actually runs, so the bench releases the lock often and sends many requests at once. A lock register that holds a stale state shows up either as a grant that survives its holder's dropped request for one cycle too long, or as a grant that moves while its holder still requests. The hold-state assertions catch both on the edge right after the fault, and the bench catches them on the next sample. A one-hot register that disagrees with the index shows up at once on the output ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   // Upper bound on channel count accepted by the elaboration checks.
   localparam int unsigned ARB_MAX_CH = 32;

   // Ownership state of the grant register.
   typedef enum logic {
      ARB_IDLE   = 1'b0,
      ARB_LOCKED = 1'b1
   } arb_state_e;

endpackage

// File: rtl/dma_arb_swap_map.sv
// Computes the neighbour-swap vector from the bandwidth fields and the
// resulting rank list (position 0 = highest priority).
module dma_arb_swap_map #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CTRL_W = 3,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CH*CTRL_W-1:0]      bw_fields,
   output logic [NUM_CH-1:0]             swap_up,
   output logic [NUM_CH-1:0][IDX_W-1:0]  rank_ch
);

   logic [NUM_CH-1:0] fld_zero;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_zero
         assign fld_zero[gi] = ~|bw_fields[gi*CTRL_W +: CTRL_W];
      end

      // Channel 0 has no lower neighbour: it never moves up.
      assign swap_up[0] = 1'b0;

      for (gi = 1; gi < NUM_CH; gi++) begin : g_swap
         // Move up only past a non-zero neighbour that is not itself swapped.
         assign swap_up[gi] = fld_zero[gi] & ~fld_zero[gi-1] & ~swap_up[gi-1];
      end

      for (gi = 0; gi < NUM_CH; gi++) begin : g_rank
         localparam logic [IDX_W-1:0] SELF = IDX_W'(gi);
         if (gi == NUM_CH - 1) begin : g_top
            assign rank_ch[gi] = swap_up[gi] ? IDX_W'(gi - 1) : SELF;
         end else if (gi == 0) begin : g_bot
            assign rank_ch[gi] = swap_up[gi+1] ? IDX_W'(gi + 1) : SELF;
         end else begin : g_mid
            assign rank_ch[gi] = swap_up[gi+1] ? IDX_W'(gi + 1) :
                                 swap_up[gi]   ? IDX_W'(gi - 1) : SELF;
         end
      end
   endgenerate

   // R4: two adjacent channels never both move up, so no swap chains.
   generate
      for (gi = 1; gi < NUM_CH; gi++) begin : g_chk
         assert_swap_pairwise_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            !(swap_up[gi] && swap_up[gi-1]));
      end
   endgenerate

   // R3: the rank list stays a permutation (each channel appears once).
   always_comb begin : rank_perm_chk
      logic [NUM_CH-1:0] seen;
      seen = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         seen[rank_ch[k]] = 1'b1;
      end
      if (rst_n) begin
         assert_rank_permutation_R3 : assert (&seen);
      end
   end

endmodule

// File: rtl/dma_arb_pick.sv
// Chooses the highest-ranked requesting channel from a rank list.
module dma_arb_pick #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0]             req,
   input  logic [NUM_CH-1:0][IDX_W-1:0]  rank_ch,
   output logic                          win_vld,
   output logic [IDX_W-1:0]              win_idx,
   output logic [NUM_CH-1:0]             win_oh
);

   logic [NUM_CH-1:0] req_by_rank;

   genvar gp;
   generate
      for (gp = 0; gp < NUM_CH; gp++) begin : g_perm
         assign req_by_rank[gp] = req[rank_ch[gp]];
      end
   endgenerate

   // Scan from lowest rank to highest; the last hit (position 0 side) wins.
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         if (req_by_rank[k]) begin
            win_vld = 1'b1;
            win_idx = rank_ch[k];
         end
      end
   end

   always_comb begin
      win_oh = '0;
      if (win_vld) begin
         win_oh[win_idx] = 1'b1;
      end
   end

endmodule

// File: rtl/dma_arb_hold.sv
// Grant register with lock: holds the owner until it drops its request.
module dma_arb_hold
   import dma_arb_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  req,
   input  logic               win_vld,
   input  logic [IDX_W-1:0]   win_idx,
   input  logic [NUM_CH-1:0]  win_oh,
   output logic [NUM_CH-1:0]  gnt,
   output logic [IDX_W-1:0]   gnt_idx,
   output logic               gnt_vld
);

   arb_state_e        st_q, st_d;
   logic [NUM_CH-1:0] oh_q, oh_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic              owner_busy;

   assign owner_busy = (st_q == ARB_LOCKED) && |(req & oh_q);

   always_comb begin
      st_d  = st_q;
      oh_d  = oh_q;
      idx_d = idx_q;
      if (!owner_busy) begin
         if (win_vld) begin
            st_d  = ARB_LOCKED;
            oh_d  = win_oh;
            idx_d = win_idx;
         end else begin
            st_d  = ARB_IDLE;
            oh_d  = '0;
            idx_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ARB_IDLE;
         oh_q  <= '0;
         idx_q <= '0;
      end else begin
         st_q  <= st_d;
         oh_q  <= oh_d;
         idx_q <= idx_d;
      end
   end

   assign gnt     = oh_q;
   assign gnt_idx = idx_q;
   assign gnt_vld = (st_q == ARB_LOCKED);

   // R8: a busy owner keeps the grant on the next cycle.
   assert_lock_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && |(req & gnt)) |=> (gnt == $past(gnt) && gnt_idx == $past(gnt_idx)));

   // R7: any grant goes to a channel that requested at the deciding edge.
   assert_grant_requested_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> |($past(req) & gnt));

   // R10: grant vector is one-hot or zero.
   assert_grant_onehot_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R10: valid flag and index agree with the one-hot vector.
   assert_valid_matches_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld == (gnt != '0)) && (!gnt_vld || gnt[gnt_idx]));

   // R9: no request at an edge leaves the arbiter idle afterwards.
   assert_idle_after_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (!gnt_vld && gnt_idx == '0));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
   import dma_arb_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CTRL_W = 3,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ch_req,
   input  logic [NUM_CH*CTRL_W-1:0]  ch_bw,
   output logic [NUM_CH-1:0]         gnt,
   output logic [IDX_W-1:0]          gnt_idx,
   output logic                      gnt_vld
);

   generate
      if (NUM_CH < 2 || NUM_CH > ARB_MAX_CH) begin : g_bad_ch
         $error("dma_prio_arb: NUM_CH out of range");
      end
      if (CTRL_W < 1) begin : g_bad_w
         $error("dma_prio_arb: CTRL_W must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0]             swap_up;
   logic [NUM_CH-1:0][IDX_W-1:0]  rank_ch;
   logic                          win_vld;
   logic [IDX_W-1:0]              win_idx;
   logic [NUM_CH-1:0]             win_oh;

   dma_arb_swap_map #(
      .NUM_CH (NUM_CH),
      .CTRL_W (CTRL_W)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .bw_fields (ch_bw),
      .swap_up   (swap_up),
      .rank_ch   (rank_ch)
   );

   dma_arb_pick #(
      .NUM_CH (NUM_CH)
   ) u_pick (
      .req     (ch_req),
      .rank_ch (rank_ch),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_oh  (win_oh)
   );

   dma_arb_hold #(
      .NUM_CH (NUM_CH)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ch_req),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_oh  (win_oh),
      .gnt     (gnt),
      .gnt_idx (gnt_idx),
      .gnt_vld (gnt_vld)
   );

   // R6: channel 0 never moves up in rank.
   assert_ch0_fixed_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !swap_up[0]);

   // R2: with no swaps active, a pending channel 0 request wins an arbitration.
   assert_base_order_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (swap_up == '0 && ch_req[0] && !(gnt_vld && |(ch_req & gnt)))
      |=> (gnt_idx == '0 && gnt_vld));

endmodule

// File: tb/dma_prio_arb_test.sv
`timescale 1ns/1ps
module dma_prio_arb_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  ch_req;
   logic [11:0] ch_bw;
   logic [3:0]  gnt;
   logic [1:0]  gnt_idx;
   logic        gnt_vld;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference state
   bit       m_vld = 1'b0;
   int       m_idx = 0;

   always #5 clk = ~clk;

   dma_prio_arb uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .ch_req  (ch_req),
      .ch_bw   (ch_bw),
      .gnt     (gnt),
      .gnt_idx (gnt_idx),
      .gnt_vld (gnt_vld)
   );

   function automatic logic [11:0] bw(int f0, int f1, int f2, int f3);
      return {3'(f3), 3'(f2), 3'(f1), 3'(f0)};
   endfunction

   // Winner from requirements: start with rank = channel, apply pairwise
   // swaps scanning upward, a swapped channel is not reused.
   function automatic int ref_pick(logic [3:0] r, logic [11:0] c);
      int rank[4];
      bit used[4];
      int best, best_rank;
      for (int i = 0; i < 4; i++) begin
         rank[i] = i;
         used[i] = 1'b0;
      end
      for (int i = 1; i < 4; i++) begin
         if (c[3*i +: 3] == 3'd0 && c[3*(i-1) +: 3] != 3'd0 && !used[i-1]) begin
            rank[i]   = i - 1;
            rank[i-1] = i;
            used[i]   = 1'b1;
            used[i-1] = 1'b1;
         end
      end
      best = -1;
      best_rank = 99;
      for (int i = 0; i < 4; i++) begin
         if (r[i] && rank[i] < best_rank) begin
            best = i;
            best_rank = rank[i];
         end
      end
      return best;
   endfunction

   task automatic check_out(input string tag);
      logic [3:0] eg;
      logic [1:0] ei;
      eg = m_vld ? (4'b1 << m_idx) : 4'b0;
      ei = m_vld ? 2'(m_idx) : 2'd0;
      checks++;
      if (gnt !== eg || gnt_idx !== ei || gnt_vld !== m_vld) begin
         fails++;
         $display("FAIL %s: got gnt=%b idx=%0d vld=%b exp gnt=%b idx=%0d vld=%b",
                  tag, gnt, gnt_idx, gnt_vld, eg, ei, m_vld);
      end
   endtask

   // Called at a falling edge: drive, predict, wait one edge, check.
   task automatic step(input logic [3:0] r, input logic [11:0] c, input string tag);
      int w;
      ch_req = r;
      ch_bw  = c;
      if (!(m_vld && r[m_idx])) begin
         w = ref_pick(r, c);
         if (w >= 0) begin
            m_vld = 1'b1;
            m_idx = w;
         end else begin
            m_vld = 1'b0;
            m_idx = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic release_all();
      step(4'b0000, bw(1, 1, 1, 1), "R10 idle");
   endtask

   initial begin
      rst_n  = 1'b0;
      ch_req = 4'b1111;
      ch_bw  = bw(1, 1, 1, 1);
      @(negedge clk);
      @(negedge clk);
      check_out("R1 during reset");
      ch_req = 4'b0000;
      rst_n  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_out("R1 after reset");

      step(4'b1111, bw(2, 5, 7, 1), "R2 all request");
      release_all();
      step(4'b1100, bw(1, 1, 1, 1), "R2 upper pair");
      release_all();
      step(4'b1100, bw(1, 1, 1, 0), "R3 ch3 over ch2");
      release_all();
      step(4'b1111, bw(1, 1, 1, 0), "R3 ch0 still first");
      release_all();
      step(4'b1010, bw(1, 1, 1, 0), "R3 ch1 over ch3");
      release_all();
      step(4'b0111, bw(4, 0, 0, 4), "R4 ch1 top");
      release_all();
      step(4'b0101, bw(4, 0, 0, 4), "R4 ch2 zero no effect");
      release_all();
      step(4'b1100, bw(4, 0, 0, 4), "R4 ch2 over ch3");
      release_all();
      step(4'b0011, bw(0, 0, 3, 3), "R5 both zero ascending");
      release_all();
      step(4'b0110, bw(6, 6, 6, 6), "R5 equal nonzero");
      release_all();
      step(4'b0011, bw(0, 2, 2, 2), "R6 ch0 field inert");
      release_all();
      step(4'b0100, bw(1, 1, 1, 1), "R7 single request");
      step(4'b0101, bw(1, 1, 1, 1), "R8 lock vs ch0");
      step(4'b1111, bw(1, 0, 1, 0), "R8 lock vs fields");
      step(4'b1011, bw(1, 1, 1, 1), "R9 rearbitrate");
      step(4'b1010, bw(1, 0, 1, 1), "R9 after ch0 drop");
      step(4'b0000, bw(1, 1, 1, 1), "R10 all dropped");

      void'($urandom(32'd20240611));
      for (int n = 0; n < 600; n++) begin
         logic [11:0] c;
         logic [3:0]  r;
         for (int i = 0; i < 4; i++) begin
            c[3*i +: 3] = ($urandom % 3 == 0) ? 3'd0 : 3'(($urandom % 7) + 1);
         end
         r = 4'($urandom);
         if ($urandom % 4 == 0) r = r & ~(m_vld ? (4'b1 << m_idx) : 4'b0);
         step(r, c, "R3/R8 random mix");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule